// File: doc/BRIEF.md
# 32-bit Arithmetic-Logic Unit

A purely combinational arithmetic-logic unit for a 32-bit integer pipeline. A 4-bit operation code chooses one of fourteen functions over two operands, A and B, and the unit returns a 32-bit result, a zero flag and a signed-overflow flag in the same cycle. Operand selection, immediate extension and register write-back belong to the surrounding pipeline.

The functions are add and subtract (each in a flagging and a non-flagging form), the four bitwise logic functions, signed and unsigned set-on-less-than, a function that places the low half of B in the upper half of the result, and three shifts. In the shifts, B is the value moved and the low five bits of A give the distance.

Top module: `alu_top`

## Requirements
- R1: Codes 0000 and 0010 return A + B modulo 2^32.
- R2: Codes 0001 and 0011 return A - B modulo 2^32.
- R3: The overflow flag is 1 only for code 0010 or 0011 and only when the true signed sum or difference lies outside the signed 32-bit range. It is 0 for every other code, including 0000 and 0001 with the same operands.
- R4: Code 0100 returns A AND B, 0101 returns A OR B, 0110 returns A XOR B, and 0111 returns NOT (A OR B).
- R5: Code 1000 returns B[15:0] in bits 31:16, with bits 15:0 zero.
- R6: Code 1011 returns 1 when A < B as two's-complement numbers and 0 otherwise. Code 1010 performs the same test on unsigned numbers.
- R7: Code 1110 shifts B left, 1101 shifts B right filling with zeros, and 1100 shifts B right filling with B[31]. The distance is A[4:0], and A[31:5] has no effect.
- R8: The zero flag is 1 exactly when all 32 result bits are 0.
- R9: Codes 1001 and 1111 return a result of 0, with overflow 0 and zero 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opCode | input | 4 | Operation select |
| opA | input | 32 | Operand A; shift distance for the shift codes |
| opB | input | 32 | Operand B; value shifted by the shift codes |
| result | output | 32 | Function result |
| zero | output | 1 | Result is all zeros |
| overflow | output | 1 | Signed overflow on codes 0010 and 0011 |

## Verification
The checker treats the unit as settled combinational logic. It evaluates a property only when the operation code and both operands are free of X or Z, so it assumes the driver always presents fully known values. The stimulus keeps to this. Inputs change only at the rising clock edge and always carry defined values drawn from the full 16-code space. Results are read at the falling edge, after the logic has settled.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADDU = 4'b0000,
    OP_SUBU = 4'b0001,
    OP_ADDS = 4'b0010,
    OP_SUBS = 4'b0011,
    OP_AND  = 4'b0100,
    OP_OR   = 4'b0101,
    OP_XOR  = 4'b0110,
    OP_NOR  = 4'b0111,
    OP_UPPR = 4'b1000,
    OP_SLTU = 4'b1010,
    OP_SLTS = 4'b1011,
    OP_SRA  = 4'b1100,
    OP_SRL  = 4'b1101,
    OP_SLL  = 4'b1110
  } aluOp_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logicKind_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RIGHT = 2'd1,
    SH_ARITH = 2'd2
  } shiftKind_e;

  typedef struct packed {
    logic       useArith;
    logic       subtract;
    logic       ovfEnable;
    logic       useLogic;
    logicKind_e logicKind;
    logic       useSlt;
    logic       sltSigned;
    logic       useUpper;
    logic       useShift;
    shiftKind_e shiftKind;
  } aluCtrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [3:0] opCode,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (opCode)
      OP_ADDU: ctrl.useArith = 1'b1;
      OP_ADDS: begin
        ctrl.useArith  = 1'b1;
        ctrl.ovfEnable = 1'b1;
      end
      OP_SUBU: begin
        ctrl.useArith = 1'b1;
        ctrl.subtract = 1'b1;
      end
      OP_SUBS: begin
        ctrl.useArith  = 1'b1;
        ctrl.subtract  = 1'b1;
        ctrl.ovfEnable = 1'b1;
      end
      OP_AND: begin
        ctrl.useLogic  = 1'b1;
        ctrl.logicKind = LG_AND;
      end
      OP_OR: begin
        ctrl.useLogic  = 1'b1;
        ctrl.logicKind = LG_OR;
      end
      OP_XOR: begin
        ctrl.useLogic  = 1'b1;
        ctrl.logicKind = LG_XOR;
      end
      OP_NOR: begin
        ctrl.useLogic  = 1'b1;
        ctrl.logicKind = LG_NOR;
      end
      OP_UPPR: ctrl.useUpper = 1'b1;
      OP_SLTU: begin
        ctrl.useSlt   = 1'b1;
        ctrl.subtract = 1'b1;
      end
      OP_SLTS: begin
        ctrl.useSlt    = 1'b1;
        ctrl.subtract  = 1'b1;
        ctrl.sltSigned = 1'b1;
      end
      OP_SRA: begin
        ctrl.useShift  = 1'b1;
        ctrl.shiftKind = SH_ARITH;
      end
      OP_SRL: begin
        ctrl.useShift  = 1'b1;
        ctrl.shiftKind = SH_RIGHT;
      end
      OP_SLL: begin
        ctrl.useShift  = 1'b1;
        ctrl.shiftKind = SH_LEFT;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  aluCtrl_t         ctrl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow
);

  localparam int MSB   = WIDTH - 1;
  localparam int HALF  = WIDTH / 2;
  localparam int SHW   = $clog2(WIDTH);

  // Shared adder: subtraction as A + ~B + 1
  logic [WIDTH-1:0] addend;
  logic [WIDTH-1:0] sum;
  logic             carryOut;
  logic             ovfRaw;

  assign addend            = ctrl.subtract ? ~opB : opB;
  assign {carryOut, sum}   = {1'b0, opA} + {1'b0, addend} + {{WIDTH{1'b0}}, ctrl.subtract};
  assign ovfRaw            = (opA[MSB] == addend[MSB]) && (sum[MSB] != opA[MSB]);

  // Comparison derived from the subtract
  logic lessThan;
  assign lessThan = ctrl.sltSigned ? (sum[MSB] ^ ovfRaw) : ~carryOut;

  // Bitwise logic
  logic [WIDTH-1:0] logicOut;
  always_comb begin
    unique case (ctrl.logicKind)
      LG_AND:  logicOut = opA & opB;
      LG_OR:   logicOut = opA | opB;
      LG_XOR:  logicOut = opA ^ opB;
      default: logicOut = ~(opA | opB);
    endcase
  end

  // Log-depth barrel shifters
  logic [SHW-1:0]   shAmt;
  logic             fillBit;
  logic [WIDTH-1:0] rStage [0:SHW];
  logic [WIDTH-1:0] lStage [0:SHW];

  assign shAmt     = opA[SHW-1:0];
  assign fillBit   = (ctrl.shiftKind == SH_ARITH) & opB[MSB];
  assign rStage[0] = opB;
  assign lStage[0] = opB;

  for (genvar k = 0; k < SHW; k++) begin : g_shift
    localparam int STEP = 1 << k;
    assign rStage[k+1] = shAmt[k] ? {{STEP{fillBit}}, rStage[k][MSB:STEP]} : rStage[k];
    assign lStage[k+1] = shAmt[k] ? {lStage[k][MSB-STEP:0], {STEP{1'b0}}} : lStage[k];
  end

  logic [WIDTH-1:0] shiftOut;
  assign shiftOut = (ctrl.shiftKind == SH_LEFT) ? lStage[SHW] : rStage[SHW];

  // Result selection
  always_comb begin
    if (ctrl.useArith)      result = sum;
    else if (ctrl.useLogic) result = logicOut;
    else if (ctrl.useSlt)   result = {{(WIDTH-1){1'b0}}, lessThan};
    else if (ctrl.useUpper) result = {opB[HALF-1:0], {HALF{1'b0}}};
    else if (ctrl.useShift) result = shiftOut;
    else                    result = '0;
  end

  assign zero     = ~|result;
  assign overflow = ctrl.useArith & ctrl.ovfEnable & ovfRaw;

endmodule

// File: rtl/alu_top.sv
module alu_top
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       opCode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow
);

  aluCtrl_t ctrl;

  alu_decode u_decode (
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_datapath (
    .ctrl     (ctrl),
    .opA      (opA),
    .opB      (opB),
    .result   (result),
    .zero     (zero),
    .overflow (overflow)
  );

endmodule

// File: rtl/alu_top_checker.sv
module alu_top_checker #(
  parameter int WIDTH = 32
) (
  input logic [3:0]       opCode,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input logic             overflow
);

  localparam int HALF = WIDTH / 2;

  logic known;
  assign known = !$isunknown({opCode, opA, opB});

  always_comb begin
    if (known) begin
      // R3
      no_overflow_chk: assert (!overflow || opCode == 4'b0010 || opCode == 4'b0011)
        else $error("overflow raised on code %b", opCode);
      // R4
      and_subset_chk: assert (opCode != 4'b0100 || (result & ~opA) == '0)
        else $error("AND result has bits outside A");
      // R5
      upper_low_chk: assert (opCode != 4'b1000 || result[HALF-1:0] == '0)
        else $error("upper-half result has low bits set");
      // R6
      slt_bool_chk: assert (!(opCode == 4'b1010 || opCode == 4'b1011) || result[WIDTH-1:1] == '0)
        else $error("compare result not 0 or 1");
      // R8
      zero_flag_chk: assert (!zero || result == '0)
        else $error("zero flag with nonzero result");
      // R9
      unused_code_chk: assert (!(opCode == 4'b1001 || opCode == 4'b1111) || (result == '0 && zero))
        else $error("unused code gave nonzero result");
    end
  end

endmodule

bind alu_top alu_top_checker #(.WIDTH(WIDTH)) u_checker (
  .opCode   (opCode),
  .opA      (opA),
  .opB      (opB),
  .result   (result),
  .zero     (zero),
  .overflow (overflow)
);

// File: tb/alu_top_bench.sv
`timescale 1ns/1ps
module alu_top_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opCode = 4'd0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [31:0] result;
  logic        zero;
  logic        overflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  alu_top u_alu_top (
    .opCode   (opCode),
    .opA      (opA),
    .opB      (opB),
    .result   (result),
    .zero     (zero),
    .overflow (overflow)
  );

  function automatic logic [32:0] model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    logic        v;
    logic signed [32:0] wide;
    r = '0; v = 1'b0;
    case (op)
      4'b0000: r = a + b;
      4'b0001: r = a - b;
      4'b0010: begin
        wide = $signed({a[31], a}) + $signed({b[31], b});
        r = wide[31:0]; v = wide[32] != wide[31];
      end
      4'b0011: begin
        wide = $signed({a[31], a}) - $signed({b[31], b});
        r = wide[31:0]; v = wide[32] != wide[31];
      end
      4'b0100: r = a & b;
      4'b0101: r = a | b;
      4'b0110: r = a ^ b;
      4'b0111: r = ~(a | b);
      4'b1000: r = {b[15:0], 16'h0};
      4'b1010: r = {31'd0, a < b};
      4'b1011: r = {31'd0, $signed(a) < $signed(b)};
      4'b1100: r = $unsigned($signed(b) >>> a[4:0]);
      4'b1101: r = b >> a[4:0];
      4'b1110: r = b << a[4:0];
      default: r = '0;
    endcase
    return {v, r};
  endfunction

  function automatic string tagFor(input logic [3:0] op);
    case (op)
      4'b0000, 4'b0010: return "R1";
      4'b0001, 4'b0011: return "R2";
      4'b0100, 4'b0101, 4'b0110, 4'b0111: return "R4";
      4'b1000: return "R5";
      4'b1010, 4'b1011: return "R6";
      4'b1100, 4'b1101, 4'b1110: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    opCode = op; opA = a; opB = b;
    @(negedge clk);
  endtask

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", tag, opCode, opA, opB, act, exp);
    end
  endtask

  task automatic fullCheck(input string tag);
    logic [32:0] e;
    e = model(opCode, opA, opB);
    checkVal(tag, result, e[31:0]);
    checkVal("R3", {31'd0, overflow}, {31'd0, e[32]});
    checkVal("R8", {31'd0, zero}, {31'd0, e[31:0] == 32'd0});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state: code 0 with zero operands
    checkVal("R8", {31'd0, zero}, 32'd1);
    checkVal("R1", result, 32'd0);

    // R1 / R3 flagging versus non-flagging add
    apply(4'b0010, 32'h7fff_ffff, 32'd1); fullCheck("R1");
    checkVal("R3", {31'd0, overflow}, 32'd1);
    apply(4'b0000, 32'h7fff_ffff, 32'd1); fullCheck("R1");
    checkVal("R3", {31'd0, overflow}, 32'd0);
    apply(4'b0010, 32'h8000_0000, 32'h8000_0000); fullCheck("R1");
    // R2 / R3 subtract corners
    apply(4'b0011, 32'h8000_0000, 32'd1); fullCheck("R2");
    checkVal("R3", {31'd0, overflow}, 32'd1);
    apply(4'b0001, 32'h8000_0000, 32'd1); fullCheck("R2");
    apply(4'b0011, 32'd5, 32'd5); fullCheck("R2");
    checkVal("R8", {31'd0, zero}, 32'd1);
    // R4 logic functions
    apply(4'b0111, 32'h0, 32'h0); fullCheck("R4");
    apply(4'b0100, 32'hf0f0_ff00, 32'h0ff0_f0f0); fullCheck("R4");
    // R5 upper half
    apply(4'b1000, 32'hdead_beef, 32'h1234_abcd); fullCheck("R5");
    checkVal("R5", result, 32'habcd_0000);
    // R6 signed versus unsigned compare
    apply(4'b1011, 32'hffff_ffff, 32'd1); checkVal("R6", result, 32'd1);
    apply(4'b1010, 32'hffff_ffff, 32'd1); checkVal("R6", result, 32'd0);
    apply(4'b1011, 32'h8000_0000, 32'h7fff_ffff); checkVal("R6", result, 32'd1);
    apply(4'b1010, 32'd7, 32'd7); checkVal("R6", result, 32'd0);
    // R7 shifts, upper A bits ignored
    apply(4'b1100, 32'hffff_ffe4, 32'h8000_0010); checkVal("R7", result, 32'hf800_0001);
    apply(4'b1101, 32'h0000_0024, 32'h8000_0010); checkVal("R7", result, 32'h0800_0001);
    apply(4'b1110, 32'h0000_003f, 32'h0000_0003); checkVal("R7", result, 32'h8000_0000);
    apply(4'b1101, 32'h0000_0020, 32'h1234_5678); checkVal("R7", result, 32'h1234_5678);
    // R9 unused codes
    apply(4'b1001, 32'h7fff_ffff, 32'h7fff_ffff); fullCheck("R9");
    checkVal("R9", {31'd0, zero}, 32'd1);
    apply(4'b1111, 32'hffff_ffff, 32'h1); fullCheck("R9");

    // random mix over all 16 codes
    for (int i = 0; i < 3000; i++) begin
      logic [3:0]  op;
      logic [31:0] a, b;
      op = 4'($urandom);
      a  = $urandom;
      b  = $urandom;
      if (i % 7 == 0) b = a;
      if (i % 11 == 0) a = {a[31], 31'h7fff_ffff};
      apply(op, a, b);
      fullCheck(tagFor(op));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule